// File: doc/BRIEF.md
# Self-Synchronizing PRBS Error Checker

This block checks a serial stream that should carry a pseudo-random binary sequence. Bits arrive one per cycle in which `bit_valid` is high. No seed is needed. The block keeps a local shift register that runs the same feedback polynomial as the transmitter. While it is hunting for lock, the register is loaded from the received bits. Once the stream has matched the local prediction for a long enough run, the block switches the register to load its own prediction. From then on, each received bit is compared against a sequence generated independently inside the block.

While locked, the block counts received bits and errored bits. A per-bit error strobe shows every mismatch, locked or not. Software that decides the link has gone bad pulses `resync`, which drops lock and returns the block to hunting. A slipped or duplicated bit turns the locked error stream into the same sequence shifted in time. Feeding the error strobe into a second copy of the block therefore detects slips: that copy gains lock only after a slip.

Top module: `prbs_lock_checker`

## Requirements
- R1: With the default parameters (7-stage register, polynomial x^7+x^6+1, tap mask 7'h60, where tap bit i is the register stage holding the bit received i+1 valid bits ago), the predicted bit is the XOR of the tapped stages. A clean sequence from a generator with this polynomial, whose period is 127 bits, reaches lock within WIDTH+RUN_LEN valid bits.
- R2: While unlocked, the register loads the received bit. `sync` rises on the edge of the valid bit that completes RUN_LEN (default 32) consecutive matching bits, and never earlier. Any mismatch restarts the run.
- R3: While locked, the register loads its own prediction, so a single corrupted input bit gives exactly one error indication and one count, with no multiplication.
- R4: Once set, `sync` stays high whatever the input until `resync` is asserted.
- R5: `err_strobe` is high for exactly the one cycle after the clock edge that takes in a valid bit differing from the prediction, and is low after any cycle without a valid bit.
- R6: `bit_count` and `err_count` advance only on valid bits processed while already locked. The bit that sets `sync` is not counted.
- R7: When every register stage is zero, the prediction is forced to one, so an all-zeros input never gains lock.
- R8: A second instance fed with the first one's error strobe (its valid input is `bit_valid` delayed one cycle) gains lock after one input bit is dropped from a locked stream. It stays unlocked while the stream is clean.
- R9: After reset, and on the edge following a cycle with `resync` high, `sync` is low, both counters are zero and `err_strobe` is low. `resync` takes priority over a valid bit in the same cycle.
- R10: Both counters are CNT_W bits wide (default 32) and saturate at all-ones instead of wrapping.
- R11: In a cycle with `bit_valid` low, the register, run counter and statistics counters hold, and `err_strobe` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Received serial bit |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| resync | input | 1 | Forces loss of lock and clears statistics |
| sync | output | 1 | Lock flag, closed-loop operation |
| err_strobe | output | 1 | Registered mismatch pulse, one per errored bit |
| err_count | output | CNT_W | Saturating count of errors while locked |
| bit_count | output | CNT_W | Saturating count of bits while locked |

## Verification
The checker sees five kinds of input:
- A clean sequence from a reference generator, which shows that lock is reached.
- A resync of a checker already in phase, which pins lock to exactly the 32nd bit.
- A random mix of valid gaps and sparse injected errors while locked. This separates single error reporting from multiplied error reporting and tallies the counters against the injected totals.
- An all-zeros stream, which must never lock.
- A dropped bit, which a second instance must detect by locking onto the error stream. That second instance is built with narrow counters, which exposes saturation.

// File: rtl/prbs_lock_checker.sv
module prbs_lock_checker #(
  parameter int WIDTH   = 7,
  parameter logic [WIDTH-1:0] TAPS = 7'h60,
  parameter int RUN_LEN = 32,
  parameter int CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             bit_valid,
  input  logic             resync,
  output logic             sync,
  output logic             err_strobe,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] bit_count
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [WIDTH-1:0] sr;
  logic [RUN_W-1:0] run;

  wire pred = (^(sr & TAPS)) | ~(|sr);
  wire miss = bit_in ^ pred;
  wire feed = sync ? pred : bit_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr         <= '0;
      run        <= '0;
      sync       <= 1'b0;
      err_strobe <= 1'b0;
      err_count  <= '0;
      bit_count  <= '0;
    end else begin
      if (bit_valid) sr <= {sr[WIDTH-2:0], feed};
      if (resync) begin
        run        <= '0;
        sync       <= 1'b0;
        err_strobe <= 1'b0;
        err_count  <= '0;
        bit_count  <= '0;
      end else if (bit_valid) begin
        err_strobe <= miss;
        if (sync) begin
          if (bit_count != '1) bit_count <= bit_count + 1'b1;
          if (miss && err_count != '1) err_count <= err_count + 1'b1;
        end else if (miss) begin
          run <= '0;
        end else begin
          run <= run + 1'b1;
          if (run == RUN_LAST) sync <= 1'b1;
        end
      end else begin
        err_strobe <= 1'b0;
      end
    end
  end
endmodule

module prbs_lock_checker_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic             resync,
  input logic             sync,
  input logic             err_strobe,
  input logic [CNT_W-1:0] err_count,
  input logic [CNT_W-1:0] bit_count
);
  AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && !resync) |=> sync); // R4
  AST_RESYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (!sync && !err_strobe && err_count == '0 && bit_count == '0)); // R9
  AST_STROBE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid) |=> !err_strobe); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !resync) |=> ($stable(bit_count) && $stable(err_count))); // R11
  AST_UNLOCKED_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !resync) |=> ($stable(bit_count) && $stable(err_count))); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_count == '1 && !resync) |=> bit_count == '1); // R10
  AST_ERR_NOT_ABOVE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    err_count <= bit_count); // R6
endmodule

bind prbs_lock_checker prbs_lock_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .resync(resync),
  .sync(sync), .err_strobe(err_strobe), .err_count(err_count), .bit_count(bit_count)
);

// File: tb/tb_prbs_lock_checker.sv
module tb_prbs_lock_checker;
  localparam logic [6:0] TAPS = 7'h60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0, bit_valid = 1'b0, resync = 1'b0, s_resync = 1'b0;
  logic sync, err_strobe;
  logic [31:0] err_count, bit_count;
  logic s_sync, s_strobe, v_d;
  logic [3:0] s_err, s_bits;
  int checks = 0, failures = 0;
  logic [6:0] g = 7'h5A;

  always #5 clk = ~clk;

  prbs_lock_checker dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid), .resync(resync),
    .sync(sync), .err_strobe(err_strobe), .err_count(err_count), .bit_count(bit_count));

  always_ff @(posedge clk) v_d <= rst_n & bit_valid & ~resync;

  prbs_lock_checker #(.CNT_W(4)) u_slip (
    .clk(clk), .rst_n(rst_n), .bit_in(err_strobe), .bit_valid(v_d), .resync(s_resync),
    .sync(s_sync), .err_strobe(s_strobe), .err_count(s_err), .bit_count(s_bits));

  function automatic logic gen_next();
    logic b;
    b = ^(g & TAPS);
    g = {g[5:0], b};
    return b;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic b, logic v);
    bit_in = b; bit_valid = v;
    @(posedge clk); #2;
  endtask

  task automatic do_resync();
    resync = 1'b1; s_resync = 1'b1; bit_valid = 1'b0;
    @(posedge clk); #2;
    resync = 1'b0; s_resync = 1'b0;
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int period, inj, bits, b0, e0;
    logic [6:0] start;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    chk("R9 reset sync", sync, 0);
    chk("R9 reset err_count", err_count, 0);
    chk("R9 reset bit_count", bit_count, 0);
    chk("R9 reset strobe", err_strobe, 0);

    // R1: reference generator period
    start = g; period = 0;
    do begin void'(gen_next()); period++; end while (g != start && period < 200);
    chk("R1 generator period", period, 127);

    // R1/R2: clean stream locks within WIDTH+RUN_LEN bits
    for (int i = 0; i < 39; i++) step(gen_next(), 1'b1);
    chk("R1 locked on clean stream", sync, 1);
    chk("R6 no errors counted", err_count, 0);

    // R9/R2: resync while in phase, exact lock point
    do_resync();
    chk("R9 resync sync", sync, 0);
    chk("R9 resync bit_count", bit_count, 0);
    for (int i = 0; i < 31; i++) step(gen_next(), 1'b1);
    chk("R2 not locked after 31 bits", sync, 0);
    step(gen_next(), 1'b1);
    chk("R2 locked at 32nd bit", sync, 1);
    chk("R6 locking bit not counted", bit_count, 0);
    step(gen_next(), 1'b1);
    chk("R6 first locked bit counted", bit_count, 1);

    // R11: idle cycles hold everything
    b0 = bit_count;
    for (int i = 0; i < 5; i++) begin
      step(1'($urandom_range(0, 1)), 1'b0);
      chk("R11 idle bit_count", bit_count, b0);
      chk("R11 idle strobe", err_strobe, 0);
    end

    // R3/R5/R6/R4: random gaps and sparse errors while locked
    b0 = bit_count; e0 = err_count; inj = 0; bits = 0;
    for (int i = 0; i < 800; i++) begin
      logic v, e, b;
      v = ($urandom_range(0, 3) != 0);
      e = v && ($urandom_range(0, 15) == 0);
      b = v ? gen_next() : 1'b0;
      step(b ^ e, v);
      if (v) bits++;
      if (e) inj++;
      chk("R5 strobe per bit", err_strobe, e);
    end
    chk("R3 err_count equals injected", err_count - e0, inj);
    chk("R6 bit_count equals valid bits", bit_count - b0, bits);
    chk("R4 sync held through errors", sync, 1);
    chk("R7 slip checker idle on zeros", s_sync, 0);

    // R8/R10: drop one bit, second instance must lock
    void'(gen_next());
    for (int i = 0; i < 150; i++) step(gen_next(), 1'b1);
    step(1'b0, 1'b0);
    chk("R8 slip detected", s_sync, 1);
    chk("R4 main still locked", sync, 1);
    chk("R10 narrow counter saturated", s_bits, 15);

    // R7/R6: all zeros never locks
    do_resync();
    for (int i = 0; i < 200; i++) begin
      step(1'b0, 1'b1);
      if (i > 10 && i % 50 == 0) chk("R7 zero input flagged", err_strobe, 1);
    end
    chk("R7 no lock on zeros", sync, 0);
    chk("R6 no counting unlocked", err_count, 0);

    // R1: recovery from zeros
    for (int i = 0; i < 40; i++) step(gen_next(), 1'b1);
    chk("R1 relock after zeros", sync, 1);

    // R9: resync has priority over a valid bit
    resync = 1'b1; s_resync = 1'b1;
    step(gen_next(), 1'b1);
    resync = 1'b0; s_resync = 1'b0;
    chk("R9 resync over valid", sync, 0);
    chk("R9 resync over valid strobe", err_strobe, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule